// File: doc/BRIEF.md
# Zero-Suppressing Hit Address Recorder

The recorder takes one full row of signed, pedestal-corrected pixel amplitudes at a time, 128 columns wide by default. In the cycle a row is accepted, every column is compared with a threshold. Only the columns above that threshold are kept. A priority encoder then walks the kept columns, lowest column first, and emits up to four of them per clock. Each kept column becomes one word, written into an on-chip FIFO together with its row number and amplitude. A row that has at least one hit is preceded in the FIFO by a single header word that carries the row number.

The input never stalls. A new row may arrive on any cycle. If the previous row still holds hits that have not been scanned when the new row arrives, those hits are thrown away and a sticky truncation flag records the loss. When the FIFO has no room, the words that do not fit are dropped, a saturating counter counts them, and a sticky overflow flag is raised. A single clear pulse resets both flags and the counter. A standby input freezes the scanner and makes the block ignore rows between bunch trains, while the FIFO can still be read out.

Top module: `hit_recorder`

## Requirements
- R1: A column is a hit when its 12-bit two's-complement amplitude is strictly greater than the signed `thresh_i` value presented in the cycle the row is accepted.
- R2: A header word is written in the cycle a row is accepted, and only when that row has at least one hit. A row with no hits leaves the FIFO untouched.
- R3: Hit words of a row follow its header. They appear in ascending column order, at most four per clock, starting the cycle after acceptance.
- R4: Word layout: bit 31 is 1 for a header and 0 for a hit. Bits 30:19 hold the row number, bits 18:12 the column, and bits 11:0 the amplitude. A header has zero in the column and amplitude fields.
- R5: `row_valid_i` is accepted on every cycle it is high, outside standby. Hits of the previous row that are still unscanned at that moment are discarded, and `trunc_o` is set and held.
- R6: A row with h hits is stored completely when the next row arrives ceil(h/4)+1 or more cycles after it.
- R7: Reads are first-word-fall-through. `rd_valid_o` is high while the FIFO holds data, `rd_data_o` shows the oldest word, and `rd_en_i` removes it. A read request while the FIFO is empty has no effect.
- R8: When the FIFO is full, the words that do not fit are dropped. Within a cycle, lower lanes keep priority. `drop_cnt_o` counts the dropped words and saturates, and `ovf_o` is set and held.
- R9: A pulse on `flag_clr_i` clears `ovf_o`, `trunc_o` and `drop_cnt_o`. A new drop in the same cycle takes precedence.
- R10: While `standby_i` is high, rows are ignored and the scan of the current row is frozen. It resumes from where it stopped once `standby_i` falls. FIFO reads keep working during standby.
- R11: After reset the FIFO is empty, and `ovf_o`, `trunc_o` and `drop_cnt_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Freeze scanning and ignore rows |
| thresh_i | input | 12 | Signed hit threshold |
| row_valid_i | input | 1 | A new row is present this cycle |
| row_num_i | input | 12 | Row number of the presented row |
| row_data_i | input | 1536 | Column c amplitude at bits c*12+11 : c*12 |
| rd_en_i | input | 1 | Pop the oldest FIFO word |
| rd_valid_o | output | 1 | FIFO not empty |
| rd_data_o | output | 32 | Oldest FIFO word |
| ovf_o | output | 1 | Sticky FIFO overflow |
| trunc_o | output | 1 | Sticky row truncation |
| drop_cnt_o | output | 16 | Saturating count of dropped words |
| flag_clr_i | input | 1 | Clear flags and drop counter |

## Verification
The assertions check the following on every cycle:
- The FIFO occupancy stays within its depth.
- A read request on an empty FIFO leaves the read pointer where it is.
- The encoder lanes are filled in order, with strictly ascending columns.
- The scan state does not move during standby.
- Both sticky flags stay set until a clear arrives.

Some behaviour can only be shown by the bench's scenarios:
- Signed strict-greater thresholding.
- The exact order and content of the stored words.
- Truncation when rows arrive back to back, and its absence at the minimum safe spacing.
- The exact number of dropped words when a wide row overfills the FIFO.

// File: rtl/hit_rec_pkg.sv
package hit_rec_pkg;
  localparam int ROW_W  = 12;
  localparam int COL_W  = 7;
  localparam int AMP_W  = 12;
  localparam int WORD_W = 1 + ROW_W + COL_W + AMP_W;

  typedef struct packed {
    logic             hdr;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [AMP_W-1:0] amp;
  } hit_word_t;
endpackage

// File: rtl/hit_scan.sv
module hit_scan
  import hit_rec_pkg::*;
#(
  parameter int N_COL = 128,
  parameter int LANES = 4,
  localparam int NW   = $clog2(LANES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   standby_i,
  input  logic                   row_valid_i,
  input  logic [ROW_W-1:0]       row_num_i,
  input  logic [N_COL*AMP_W-1:0] row_data_i,
  input  logic [AMP_W-1:0]       thresh_i,
  output hit_word_t              wr_word_o [LANES],
  output logic [NW-1:0]          wr_n_o,
  output logic                   trunc_o
);
  localparam logic [N_COL-1:0] ONE = N_COL'(1);

  logic [N_COL-1:0]       mask_q;
  logic [N_COL*AMP_W-1:0] data_q;
  logic [ROW_W-1:0]       row_q;
  logic [N_COL-1:0]       hit_now;
  logic                   accept;

  logic [N_COL-1:0] m   [LANES+1];
  logic [COL_W-1:0] idx [LANES];
  logic             fnd [LANES];

  function automatic logic [COL_W-1:0] low_idx(input logic [N_COL-1:0] v);
    low_idx = '0;
    for (int i = N_COL - 1; i >= 0; i--)
      if (v[i]) low_idx = COL_W'(i);
  endfunction

  assign accept = row_valid_i & ~standby_i;

  for (genvar c = 0; c < N_COL; c++) begin : g_cmp
    assign hit_now[c] = $signed(row_data_i[c*AMP_W +: AMP_W]) > $signed(thresh_i);
  end

  // lane l takes the lowest bit left after lanes 0..l-1
  assign m[0] = mask_q;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign fnd[l]   = |m[l];
    assign idx[l]   = low_idx(m[l]);
    assign m[l+1]   = m[l] & (m[l] - ONE);
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) wr_word_o[l] = '0;
    wr_n_o = '0;
    if (accept) begin
      wr_word_o[0] = '{hdr: 1'b1, row: row_num_i, col: '0, amp: '0};
      wr_n_o       = NW'(|hit_now);
    end else if (!standby_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (fnd[l]) begin
          wr_word_o[l] = '{hdr: 1'b0, row: row_q, col: idx[l],
                           amp: data_q[idx[l]*AMP_W +: AMP_W]};
          wr_n_o = wr_n_o + NW'(1);
        end
      end
    end
  end

  assign trunc_o = accept & (|mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      data_q <= '0;
      row_q  <= '0;
    end else if (accept) begin
      mask_q <= hit_now;
      data_q <= row_data_i;
      row_q  <= row_num_i;
    end else if (!standby_i) begin
      mask_q <= m[LANES];
    end
  end

  p_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> $stable(mask_q));

  for (genvar l = 1; l < LANES; l++) begin : g_ord
    p_lane_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fnd[l] |-> (fnd[l-1] && idx[l] > idx[l-1]));
  end
endmodule

// File: rtl/hit_fifo.sv
module hit_fifo
  import hit_rec_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int NW   = $clog2(LANES + 1),
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  hit_word_t     wr_word_i [LANES],
  input  logic [NW-1:0] wr_n_i,
  input  logic          rd_en_i,
  output hit_word_t     rd_word_o,
  output logic          rd_valid_o,
  output logic [NW-1:0] drop_n_o
);
  hit_word_t       mem [DEPTH];
  logic [AW-1:0]   wptr_q, rptr_q;
  logic [CW-1:0]   cnt_q, free, n_req, n_ok;
  logic            pop;

  assign pop        = rd_en_i & (cnt_q != '0);
  assign free       = CW'(DEPTH) - cnt_q;
  assign n_req      = CW'(wr_n_i);
  assign n_ok       = (n_req > free) ? free : n_req;
  assign drop_n_o   = NW'(n_req - n_ok);
  assign rd_valid_o = cnt_q != '0;
  assign rd_word_o  = mem[rptr_q];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++)
      if (CW'(l) < n_ok) mem[wptr_q + AW'(l)] <= wr_word_i[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_q + AW'(n_ok);
      rptr_q <= rptr_q + AW'(pop);
      cnt_q  <= cnt_q + n_ok - CW'(pop);
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  p_empty_pop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && cnt_q == '0) |=> $stable(rptr_q));
endmodule

// File: rtl/hit_recorder.sv
module hit_recorder
  import hit_rec_pkg::*;
#(
  parameter int N_COL  = 128,
  parameter int LANES  = 4,
  parameter int DEPTH  = 32,
  parameter int DROP_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   standby_i,
  input  logic [AMP_W-1:0]       thresh_i,
  input  logic                   row_valid_i,
  input  logic [ROW_W-1:0]       row_num_i,
  input  logic [N_COL*AMP_W-1:0] row_data_i,
  input  logic                   rd_en_i,
  output logic                   rd_valid_o,
  output logic [WORD_W-1:0]      rd_data_o,
  output logic                   ovf_o,
  output logic                   trunc_o,
  output logic [DROP_W-1:0]      drop_cnt_o,
  input  logic                   flag_clr_i
);
  localparam int NW = $clog2(LANES + 1);

  hit_word_t     wr_word [LANES];
  hit_word_t     rd_word;
  logic [NW-1:0] wr_n, drop_n;
  logic          trunc_ev;
  logic          ovf_q, trunc_q;
  logic [DROP_W-1:0] drop_q, drop_base;
  logic [DROP_W:0]   drop_sum;

  hit_scan #(.N_COL(N_COL), .LANES(LANES)) u_scan (
    .clk_i, .rst_ni, .standby_i, .row_valid_i, .row_num_i, .row_data_i,
    .thresh_i, .wr_word_o(wr_word), .wr_n_o(wr_n), .trunc_o(trunc_ev)
  );

  hit_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_fifo (
    .clk_i, .rst_ni, .wr_word_i(wr_word), .wr_n_i(wr_n), .rd_en_i,
    .rd_word_o(rd_word), .rd_valid_o, .drop_n_o(drop_n)
  );

  assign rd_data_o = rd_word;
  assign drop_base = flag_clr_i ? '0 : drop_q;
  assign drop_sum  = {1'b0, drop_base} + (DROP_W+1)'(drop_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q   <= 1'b0;
      trunc_q <= 1'b0;
      drop_q  <= '0;
    end else begin
      ovf_q   <= (drop_n != '0) | (ovf_q & ~flag_clr_i);
      trunc_q <= trunc_ev | (trunc_q & ~flag_clr_i);
      drop_q  <= drop_sum[DROP_W] ? '1 : drop_sum[DROP_W-1:0];
    end
  end

  assign ovf_o      = ovf_q;
  assign trunc_o    = trunc_q;
  assign drop_cnt_o = drop_q;

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !flag_clr_i) |=> ovf_o);

  p_trunc_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trunc_o && !flag_clr_i) |=> trunc_o);
endmodule

// File: tb/hit_recorder_bench.sv
`timescale 1ns/1ps
module hit_recorder_bench;
  import hit_rec_pkg::*;
  localparam int N_COL = 128;
  localparam int DEPTH = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic standby = 1'b0, row_valid = 1'b0, rd_en = 1'b0, flag_clr = 1'b0;
  logic [AMP_W-1:0] thresh = '0;
  logic [ROW_W-1:0] row_num = '0;
  logic [N_COL*AMP_W-1:0] row_data = '0;
  logic rd_valid, ovf, trunc;
  logic [WORD_W-1:0] rd_data;
  logic [15:0] drop_cnt;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hit_recorder #(.N_COL(N_COL), .DEPTH(DEPTH)) u_hit_recorder (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .thresh_i(thresh),
    .row_valid_i(row_valid), .row_num_i(row_num), .row_data_i(row_data),
    .rd_en_i(rd_en), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .ovf_o(ovf), .trunc_o(trunc), .drop_cnt_o(drop_cnt), .flag_clr_i(flag_clr)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic fill(logic [AMP_W-1:0] v);
    for (int c = 0; c < N_COL; c++) row_data[c*AMP_W +: AMP_W] = v;
  endtask

  task automatic put(int c, logic [AMP_W-1:0] v);
    row_data[c*AMP_W +: AMP_W] = v;
  endtask

  task automatic send_row(logic [ROW_W-1:0] r);
    row_num = r; row_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    row_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_expect(string req, bit hdr, int r, int c, logic [AMP_W-1:0] a);
    logic [31:0] exp;
    exp = {hdr, ROW_W'(r), COL_W'(c), a};
    chk(req, "rd_valid", 32'(rd_valid), 32'd1);
    chk(req, "word", rd_data, exp);
    rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic expect_empty(string req);
    chk(req, "empty", 32'(rd_valid), 32'd0);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // R11
  task automatic t_reset();
    expect_empty("R11");
    chk("R11", "ovf", 32'(ovf), 0);
    chk("R11", "trunc", 32'(trunc), 0);
    chk("R11", "drop", 32'(drop_cnt), 0);
  endtask

  // R2: values equal to threshold are not hits, nothing stored
  task automatic t_no_hits();
    thresh = 12'd100; fill(12'd100);
    send_row(12'd7); idle(4);
    expect_empty("R2");
    // R7: pop on empty ignored, next row still reads correctly
    rd_en = 1'b1; @(posedge clk); @(negedge clk); rd_en = 1'b0;
    put(9, 12'd101); send_row(12'd8); idle(3);
    pop_expect("R7", 1, 8, 0, 0);
    pop_expect("R7", 0, 8, 9, 12'd101);
    expect_empty("R7");
  endtask

  // R3 R4: six hits scattered, ascending order, two scan cycles
  task automatic t_order();
    thresh = 12'd10; fill(12'd0);
    put(127, 12'd300); put(5, 12'd55); put(0, 12'd11);
    put(64, 12'd640); put(3, 12'd33); put(9, 12'd99);
    send_row(12'hABC); idle(4);
    pop_expect("R4", 1, 12'hABC, 0, 0);
    pop_expect("R3", 0, 12'hABC, 0, 12'd11);
    pop_expect("R3", 0, 12'hABC, 3, 12'd33);
    pop_expect("R3", 0, 12'hABC, 5, 12'd55);
    pop_expect("R3", 0, 12'hABC, 9, 12'd99);
    pop_expect("R3", 0, 12'hABC, 64, 12'd640);
    pop_expect("R4", 0, 12'hABC, 127, 12'd300);
    expect_empty("R3");
  endtask

  // R1: signed strict greater-than
  task automatic t_signed();
    thresh = -12'sd5; fill(12'h800);
    put(2, -12'sd4); put(3, -12'sd5); put(4, 12'h7FF); put(5, 12'h800); put(6, 12'd0);
    send_row(12'd20); idle(3);
    pop_expect("R1", 1, 20, 0, 0);
    pop_expect("R1", 0, 20, 2, 12'hFFC);
    pop_expect("R1", 0, 20, 4, 12'h7FF);
    pop_expect("R1", 0, 20, 6, 12'h000);
    expect_empty("R1");
  endtask

  // R5: back-to-back rows discard leftovers
  task automatic t_trunc();
    thresh = 12'd0; fill(12'd0);
    for (int c = 0; c < 12; c++) put(c * 2, 12'd5);
    send_row(12'd30);
    fill(12'd0); put(77, 12'd9);
    send_row(12'd31); idle(4);
    chk("R5", "trunc", 32'(trunc), 1);
    pop_expect("R5", 1, 30, 0, 0);
    pop_expect("R5", 1, 31, 0, 0);
    pop_expect("R5", 0, 31, 77, 12'd9);
    expect_empty("R5");
    clear_flags();
    chk("R9", "trunc cleared", 32'(trunc), 0);
  endtask

  // R6: 8 hits, next row three cycles later, nothing lost
  task automatic t_spacing();
    thresh = 12'd0; fill(12'd0);
    for (int c = 0; c < 8; c++) put(c + 40, 12'(c + 1));
    send_row(12'd50); idle(2);
    fill(12'd0); send_row(12'd51); idle(2);
    chk("R6", "trunc", 32'(trunc), 0);
    pop_expect("R6", 1, 50, 0, 0);
    for (int c = 0; c < 8; c++) pop_expect("R6", 0, 50, c + 40, 12'(c + 1));
    expect_empty("R6");
  endtask

  // R8 R9: 40 hits into 32 entries
  task automatic t_overflow();
    thresh = 12'd0; fill(12'd0);
    for (int c = 0; c < 40; c++) put(c, 12'(c + 1));
    send_row(12'd60); idle(12);
    chk("R8", "ovf", 32'(ovf), 1);
    chk("R8", "drop", 32'(drop_cnt), 9);
    pop_expect("R8", 1, 60, 0, 0);
    for (int c = 0; c < 31; c++) pop_expect("R8", 0, 60, c, 12'(c + 1));
    expect_empty("R8");
    chk("R8", "ovf sticky", 32'(ovf), 1);
    clear_flags();
    chk("R9", "ovf", 32'(ovf), 0);
    chk("R9", "drop", 32'(drop_cnt), 0);
  endtask

  // R10: rows ignored in standby; scan freezes and resumes
  task automatic t_standby();
    thresh = 12'd0; fill(12'd0); put(1, 12'd3);
    standby = 1'b1; send_row(12'd70); idle(3);
    expect_empty("R10");
    standby = 1'b0;
    fill(12'd0);
    for (int c = 0; c < 8; c++) put(c + 100, 12'(c + 20));
    row_num = 12'd71; row_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    row_valid = 1'b0; standby = 1'b1;
    idle(3);
    pop_expect("R10", 1, 71, 0, 0);
    expect_empty("R10");
    standby = 1'b0; idle(3);
    for (int c = 0; c < 8; c++) pop_expect("R10", 0, 71, c + 100, 12'(c + 20));
    expect_empty("R10");
    chk("R10", "trunc", 32'(trunc), 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_no_hits();
    t_order();
    t_signed();
    t_trunc();
    t_spacing();
    t_overflow();
    t_standby();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule